// File: doc/BRIEF.md
# SPI Data Buffer and Status Registers

This block connects a byte-wide CPU register bus to an SPI shift engine. The CPU fills a 16-bit transmit holding word one byte at a time. The CPU empties a 16-bit receive holding word the same way. The block keeps three status flags: transmit-empty, receive-ready and overrun. It also produces a transmit interrupt. When the shift engine begins an exchange, it takes the transmit word from the block. When the exchange ends, the shift engine hands the received word to the block.

Only accesses to the low data byte have side effects on the flags. When a new word arrives while the previous one has not been consumed, the overrun flag is raised. In master mode the new word then replaces the old one. In slave mode the old word is kept. Dropping the enable input returns the block to its idle state, and while enable is low the engine strobes are ignored.

Register select values on the bus address are as follows: 0 is the low data byte, 1 is the high data byte, 2 is status, and 3 reads as zero. The status byte carries overrun in bit 1, transmit-empty in bit 5 and receive-ready in bit 6. All other status bits are zero. Read data is combinational from the address in the same cycle as the read strobe.

Top module: `spi_buf_regs`

## Requirements
- R1: After reset with enable high, the status byte reads 0x20: transmit-empty is 1, receive-ready is 0 and overrun is 0.
- R2: A write to select 0 stores bits [7:0] of the transmit word and clears transmit-empty. A write to select 1 stores bits [15:8] and leaves transmit-empty unchanged.
- R3: In the cycle that xchg_start is high, tx_word shows the stored transmit word. From the next cycle, transmit-empty reads 1.
- R4: If a write to select 0 and xchg_start fall in the same cycle, tx_word shows the word as it was before the write. The new byte is stored, and transmit-empty ends up 0.
- R5: A cycle with xchg_done high and no overrun stores rx_word. From the next cycle receive-ready is 1, select 0 reads rx_word[7:0] and select 1 reads rx_word[15:8].
- R6: A read of select 0 clears receive-ready. Reads of select 1 or select 2 leave it unchanged.
- R7: xchg_done arriving while receive-ready is 1, without a select-0 read in that cycle, sets overrun (status bit 1).
- R8: On such an overrun, master mode (master_mode=1) replaces the stored receive word with rx_word. Slave mode keeps the old word.
- R9: A read of select 0 or any write to select 2 clears overrun. If a new overrun occurs in the same cycle, the flag ends up set.
- R10: If xchg_done and a select-0 read fall in the same cycle, the read returns the old low byte and no overrun occurs. The new word is stored and receive-ready ends up 1.
- R11: tx_irq_pulse is high for exactly the one cycle after a cycle with xchg_start, enable and irq_en all high. tx_irq_level equals transmit-empty AND irq_en AND enable.
- R12: While enable is low, the flags hold their R1 values, xchg_done has no effect, and tx_irq_level is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Port enable; low forces the idle state |
| master_mode | input | 1 | 1 = master (overwrite on overrun), 0 = slave (keep old word) |
| irq_en | input | 1 | Transmit interrupt enable |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| xchg_start | input | 1 | Shift engine begins an exchange this cycle |
| tx_word | output | 16 | Transmit word offered to the shift engine |
| xchg_done | input | 1 | Shift engine finished an exchange this cycle |
| rx_word | input | 16 | Word received by the shift engine |
| tx_irq_pulse | output | 1 | One-cycle transmit interrupt pulse |
| tx_irq_level | output | 1 | Level transmit interrupt |

## Verification
Two pairs of events can share a cycle. A low-byte write can meet an exchange start, and a low-byte read can meet an exchange completion; a status write meeting a new overrun is a further variant. The bench provokes each collision by raising both strobes in the same cycle. It then judges the result from the word given to the engine, the byte read back and the status flags in the following cycle. Each outcome is compared with the priority the requirements state.

// File: rtl/spi_buf_pkg.sv
package spi_buf_pkg;

    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned LANES   = 2;
    localparam int unsigned WORD_W  = BYTE_W * LANES;
    localparam int unsigned SEL_W   = 2;

    localparam int unsigned STAT_OVR_BIT = 1;
    localparam int unsigned STAT_TXE_BIT = 5;
    localparam int unsigned STAT_RXR_BIT = 6;

    typedef enum logic [SEL_W-1:0] {
        SEL_DATA_LO = 2'd0,
        SEL_DATA_HI = 2'd1,
        SEL_STATUS  = 2'd2,
        SEL_NONE    = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic wr_lo;
        logic wr_hi;
        logic wr_stat;
        logic rd_lo;
    } bus_acc_t;

    typedef struct packed {
        logic tx_empty;
        logic rx_ready;
        logic overrun;
    } buf_flags_t;

    function automatic logic [BYTE_W-1:0] pack_status(input buf_flags_t f);
        logic [BYTE_W-1:0] s;
        s = '0;
        s[STAT_OVR_BIT] = f.overrun;
        s[STAT_TXE_BIT] = f.tx_empty;
        s[STAT_RXR_BIT] = f.rx_ready;
        return s;
    endfunction

endpackage

// File: rtl/spi_buf_decode.sv
module spi_buf_decode
    import spi_buf_pkg::*;
(
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [SEL_W-1:0] bus_addr,
    output bus_acc_t         acc
);
    reg_sel_e sel;

    always_comb begin
        sel         = reg_sel_e'(bus_addr);
        acc         = '0;
        acc.wr_lo   = bus_wr && (sel == SEL_DATA_LO);
        acc.wr_hi   = bus_wr && (sel == SEL_DATA_HI);
        acc.wr_stat = bus_wr && (sel == SEL_STATUS);
        acc.rd_lo   = bus_rd && (sel == SEL_DATA_LO);
    end
endmodule

// File: rtl/spi_buf_tx.sv
module spi_buf_tx
    import spi_buf_pkg::*;
#(
    parameter int unsigned LANE_W = BYTE_W,
    parameter int unsigned NLANE  = LANES,
    localparam int unsigned W     = LANE_W * NLANE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [NLANE-1:0]  lane_we,
    input  logic [LANE_W-1:0] wdata,
    input  logic              start,
    output logic [W-1:0]      tx_word,
    output logic              tx_empty
);
    logic [W-1:0] hold_q;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst || !enable) begin
                hold_q[g*LANE_W +: LANE_W] <= '0;
            end else if (lane_we[g]) begin
                hold_q[g*LANE_W +: LANE_W] <= wdata;
            end
        end
    end

    // Low-lane write has priority over the start marking the buffer empty.
    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            tx_empty <= 1'b1;
        end else if (lane_we[0]) begin
            tx_empty <= 1'b0;
        end else if (start) begin
            tx_empty <= 1'b1;
        end
    end

    assign tx_word = hold_q;

    // R2: an upper-lane write alone does not touch the empty flag
    a_r2_hi_keeps_empty: assert property (@(posedge clk) disable iff (rst)
        enable && !lane_we[0] && (|lane_we) && !start |=> $stable(tx_empty));

    // R3: a start without a colliding low write leaves the buffer empty
    a_r3_start_empties: assert property (@(posedge clk) disable iff (rst)
        enable && start && !lane_we[0] |=> tx_empty);

    // R4: a low write always leaves the buffer non-empty, start or not
    a_r4_load_wins: assert property (@(posedge clk) disable iff (rst)
        enable && lane_we[0] |=> !tx_empty);
endmodule

// File: rtl/spi_buf_rx.sv
module spi_buf_rx
    import spi_buf_pkg::*;
#(
    parameter int unsigned W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         enable,
    input  logic         master_mode,
    input  logic         done,
    input  logic [W-1:0] rx_word,
    input  logic         rd_lo,
    input  logic         wr_stat,
    output logic [W-1:0] rx_buf,
    output logic         rx_ready,
    output logic         overrun
);
    logic ovr_hit;
    logic capture;

    // A low-byte read in the same cycle consumes the old word first.
    assign ovr_hit = done && rx_ready && !rd_lo;
    assign capture = done && !(ovr_hit && !master_mode);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            rx_buf   <= '0;
            rx_ready <= 1'b0;
            overrun  <= 1'b0;
        end else begin
            if (capture) begin
                rx_buf <= rx_word;
            end
            if (done) begin
                rx_ready <= 1'b1;
            end else if (rd_lo) begin
                rx_ready <= 1'b0;
            end
            if (ovr_hit) begin
                overrun <= 1'b1;
            end else if (rd_lo || wr_stat) begin
                overrun <= 1'b0;
            end
        end
    end

    // R6: low read with no arrival empties the receive side
    a_r6_rd_clears_ready: assert property (@(posedge clk) disable iff (rst)
        enable && rd_lo && !done |=> !rx_ready);

    // R7: an arrival onto an unread word flags overrun
    a_r7_overrun_set: assert property (@(posedge clk) disable iff (rst)
        enable && done && rx_ready && !rd_lo |=> overrun);

    // R8: slave keeps the old word on overrun
    a_r8_slave_keeps: assert property (@(posedge clk) disable iff (rst)
        enable && done && rx_ready && !rd_lo && !master_mode |=> $stable(rx_buf));

    // R12: disabled port holds idle flags
    a_r12_idle_when_off: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !rx_ready && !overrun);
endmodule

// File: rtl/spi_buf_irq.sv
module spi_buf_irq (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic irq_en,
    input  logic start,
    input  logic tx_empty,
    output logic irq_pulse,
    output logic irq_level
);
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_pulse <= 1'b0;
        end else begin
            irq_pulse <= start && enable && irq_en;
        end
    end

    assign irq_level = tx_empty && irq_en && enable;

    // R11: the pulse only follows an accepted start
    a_r11_pulse_cause: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> $past(start));

    // R11: no pulse follows a cycle without a start
    a_r11_pulse_single: assert property (@(posedge clk) disable iff (rst)
        !start |=> !irq_pulse);
endmodule

// File: rtl/spi_buf_regs.sv
module spi_buf_regs
    import spi_buf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              master_mode,
    input  logic              irq_en,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [SEL_W-1:0]  bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              xchg_start,
    output logic [WORD_W-1:0] tx_word,
    input  logic              xchg_done,
    input  logic [WORD_W-1:0] rx_word,
    output logic              tx_irq_pulse,
    output logic              tx_irq_level
);
    bus_acc_t          acc;
    buf_flags_t        flags;
    logic [WORD_W-1:0] rx_buf;
    logic              tx_empty;
    logic              rx_ready;
    logic              overrun;
    logic [LANES-1:0]  lane_we;

    spi_buf_decode u_dec (
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .acc      (acc)
    );

    assign lane_we = {acc.wr_hi, acc.wr_lo};

    spi_buf_tx #(.LANE_W(BYTE_W), .NLANE(LANES)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .lane_we  (lane_we),
        .wdata    (bus_wdata),
        .start    (xchg_start),
        .tx_word  (tx_word),
        .tx_empty (tx_empty)
    );

    spi_buf_rx #(.W(WORD_W)) u_rx (
        .clk         (clk),
        .rst         (rst),
        .enable      (enable),
        .master_mode (master_mode),
        .done        (xchg_done),
        .rx_word     (rx_word),
        .rd_lo       (acc.rd_lo),
        .wr_stat     (acc.wr_stat),
        .rx_buf      (rx_buf),
        .rx_ready    (rx_ready),
        .overrun     (overrun)
    );

    spi_buf_irq u_irq (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .irq_en    (irq_en),
        .start     (xchg_start),
        .tx_empty  (tx_empty),
        .irq_pulse (tx_irq_pulse),
        .irq_level (tx_irq_level)
    );

    always_comb begin
        flags.tx_empty = tx_empty;
        flags.rx_ready = rx_ready;
        flags.overrun  = overrun;
        case (reg_sel_e'(bus_addr))
            SEL_DATA_LO: bus_rdata = rx_buf[BYTE_W-1:0];
            SEL_DATA_HI: bus_rdata = rx_buf[WORD_W-1:BYTE_W];
            SEL_STATUS:  bus_rdata = pack_status(flags);
            default:     bus_rdata = '0;
        endcase
    end

    // R9: a status write with no new overrun clears the flag
    a_r9_stat_write_clears: assert property (@(posedge clk) disable iff (rst)
        enable && acc.wr_stat && !(xchg_done && rx_ready && !acc.rd_lo) |=> !overrun);

    // R10: arrival together with a low read never raises overrun
    a_r10_no_false_overrun: assert property (@(posedge clk) disable iff (rst)
        enable && xchg_done && acc.rd_lo |=> !overrun && rx_ready);
endmodule

// File: tb/sim_spi_buf_regs.sv
module sim_spi_buf_regs;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst, enable, master_mode, irq_en;
    logic        bus_wr, bus_rd;
    logic [1:0]  bus_addr;
    logic [7:0]  bus_wdata, bus_rdata;
    logic        xchg_start, xchg_done;
    logic [15:0] tx_word, rx_word;
    logic        tx_irq_pulse, tx_irq_level;

    int checks   = 0;
    int failures = 0;

    spi_buf_regs u0 (
        .clk(clk), .rst(rst), .enable(enable), .master_mode(master_mode),
        .irq_en(irq_en), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .xchg_start(xchg_start),
        .tx_word(tx_word), .xchg_done(xchg_done), .rx_word(rx_word),
        .tx_irq_pulse(tx_irq_pulse), .tx_irq_level(tx_irq_level)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [7:0] stat_of(input logic txe, input logic rdy, input logic ovr);
        return 8'((int'(txe) << 5) | (int'(rdy) << 6) | (int'(ovr) << 1));
    endfunction

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        step();
        bus_rd = 1'b0;
    endtask

    task automatic start_xchg(output logic [15:0] w);
        xchg_start = 1'b1;
        #1 w = tx_word;
        step();
        xchg_start = 1'b0;
    endtask

    task automatic finish_xchg(input logic [15:0] w);
        xchg_done = 1'b1; rx_word = w;
        step();
        xchg_done = 1'b0;
    endtask

    task automatic check_stat(input string tag, input logic txe, input logic rdy, input logic ovr);
        logic [7:0] s;
        bus_read(2'd2, s);
        chk(tag, {8'h0, s}, {8'h0, stat_of(txe, rdy, ovr)});
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0]  d;
        logic [15:0] got, w, r1, r2, keep;
        rst = 1'b1; enable = 1'b1; master_mode = 1'b0; irq_en = 1'b1;
        bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = 2'd0; bus_wdata = 8'h0;
        xchg_start = 1'b0; xchg_done = 1'b0; rx_word = 16'h0;
        step(); step();
        rst = 1'b0;

        check_stat("R1 reset status", 1'b1, 1'b0, 1'b0);
        chk("R11 level after reset", {15'h0, tx_irq_level}, 16'h1);
        chk("R11 no pulse after reset", {15'h0, tx_irq_pulse}, 16'h0);

        for (int m = 0; m < 2; m++) begin
            for (int k = 0; k < 6; k++) begin
                master_mode = m[0];
                w  = 16'(k * 16'h2345 + 16'h0F1E);
                r1 = ~w;
                r2 = 16'((w ^ 16'h5AA5) + k);
                keep = m[0] ? r2 : r1;

                bus_write(2'd0, w[7:0]);
                chk("R11 level drops on load", {15'h0, tx_irq_level}, 16'h0);
                check_stat("R2 low write clears empty", 1'b0, 1'b0, 1'b0);
                bus_write(2'd1, w[15:8]);
                check_stat("R2 high write keeps empty", 1'b0, 1'b0, 1'b0);

                start_xchg(got);
                chk("R3 word to engine", got, w);
                chk("R11 pulse after start", {15'h0, tx_irq_pulse}, 16'h1);
                check_stat("R3 empty after start", 1'b1, 1'b0, 1'b0);
                chk("R11 pulse one cycle", {15'h0, tx_irq_pulse}, 16'h0);

                finish_xchg(r1);
                check_stat("R5 ready after done", 1'b1, 1'b1, 1'b0);
                bus_read(2'd1, d);
                chk("R5 high byte", {8'h0, d}, {8'h0, r1[15:8]});
                check_stat("R6 high read keeps ready", 1'b1, 1'b1, 1'b0);

                finish_xchg(r2);
                check_stat("R7 overrun set", 1'b1, 1'b1, 1'b1);
                bus_read(2'd1, d);
                chk("R8 word after overrun hi", {8'h0, d}, {8'h0, keep[15:8]});

                if (k % 2 == 0) begin
                    bus_write(2'd2, 8'hFF);
                    check_stat("R9 status write clears overrun", 1'b1, 1'b1, 1'b0);
                    bus_read(2'd0, d);
                    chk("R8 word after overrun lo", {8'h0, d}, {8'h0, keep[7:0]});
                    check_stat("R6 low read clears ready", 1'b1, 1'b0, 1'b0);
                end else begin
                    bus_read(2'd0, d);
                    chk("R8 word after overrun lo", {8'h0, d}, {8'h0, keep[7:0]});
                    check_stat("R9 low read clears overrun", 1'b1, 1'b0, 1'b0);
                end
            end
        end

        // R4: low write collides with start
        bus_write(2'd1, 8'h3C);
        bus_write(2'd0, 8'h11);
        bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h77; xchg_start = 1'b1;
        #1 got = tx_word;
        step();
        bus_wr = 1'b0; xchg_start = 1'b0;
        chk("R4 engine gets old word", got, 16'h3C11);
        check_stat("R4 load wins empty", 1'b0, 1'b0, 1'b0);
        start_xchg(got);
        chk("R4 new byte stored", got, 16'h3C77);

        // R10: done collides with low read
        finish_xchg(16'hC3A1);
        bus_rd = 1'b1; bus_addr = 2'd0; xchg_done = 1'b1; rx_word = 16'h1B2C;
        #1 d = bus_rdata;
        step();
        bus_rd = 1'b0; xchg_done = 1'b0;
        chk("R10 read returns old", {8'h0, d}, 16'h00A1);
        check_stat("R10 no overrun ready set", 1'b1, 1'b1, 1'b0);
        bus_read(2'd1, d);
        chk("R10 new word stored", {8'h0, d}, 16'h001B);

        // R9: new overrun wins against status write
        master_mode = 1'b1;
        bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 8'h00;
        xchg_done = 1'b1; rx_word = 16'h4455;
        step();
        bus_wr = 1'b0; xchg_done = 1'b0;
        check_stat("R9 set wins over clear", 1'b1, 1'b1, 1'b1);

        // R11: interrupt disabled
        irq_en = 1'b0;
        start_xchg(got);
        chk("R11 no pulse when disabled", {15'h0, tx_irq_pulse}, 16'h0);
        chk("R11 no level when disabled", {15'h0, tx_irq_level}, 16'h0);
        irq_en = 1'b1;

        // R12: port disabled
        enable = 1'b0;
        step();
        check_stat("R12 idle flags", 1'b1, 1'b0, 1'b0);
        finish_xchg(16'hBEEF);
        check_stat("R12 done ignored", 1'b1, 1'b0, 1'b0);
        chk("R12 level low", {15'h0, tx_irq_level}, 16'h0);
        enable = 1'b1;
        step();
        check_stat("R1 after re-enable", 1'b1, 1'b0, 1'b0);
        bus_read(2'd0, d);
        chk("R12 buffer not captured", {8'h0, d}, 16'h0000);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule